// File: doc/BRIEF.md
# Network Loop-Code Detection Controller

This block watches a recovered receive bit stream for in-band network loop codes. The stream arrives one bit per receive clock, with a valid strobe. A remote terminal sends these codes to ask a line interface to loop its traffic back or to release it. The block recognises two repeating codes. The loop-up code is a 5-bit period, and the loop-down code is a 3-bit period. A code counts only once it has been received without a break for longer than a hold time. The hold time is given as a parameter in receive bits, and it stands for the five-second rule used on the line.

A two-bit mode input selects the behaviour. In the two manual modes, a status bit reports whether the chosen code is currently qualified. The host then decides what to do. In automatic mode, the block itself grants remote loop-back when the loop-up code qualifies and keeps it after the code stops. It then watches for the loop-down code, which releases loop-back. Automatic mode is suppressed by one test-mode setting. No loop-back is granted while local analog loop-back is on. Each change of the status bit can raise a one-cycle interrupt pulse.

Top module: `loop_code_ctrl`

## Requirements
- R1: Mode encoding is `mode_sel` 2'b00 disabled, 2'b01 manual loop-up, 2'b10 manual loop-down, 2'b11 automatic. While disabled, `code_status` and `remote_loop_en` are 0 from the next clock on.
- R2: Each code is tracked in phase. The loop-up code repeats 0,0,0,0,1 and the loop-down code repeats 0,0,1. Matching starts at the first 0 of the period. A valid bit equal to the expected bit advances the phase and adds one to the run length. A mismatching bit sets the run length to 0. After a mismatching 1, the next bit expected is the first 0 of the period. After a mismatching 0, the next bit expected is the closing 1.
- R3: A code qualifies when its run length exceeds `HOLD_CYCLES`. The status output rises one clock after the edge that samples the (`HOLD_CYCLES`+1)-th consecutive matching bit.
- R4: In a manual mode, `code_status` follows the qualification of the selected code, one clock late. `remote_loop_en` stays 0.
- R5: When the effective mode changes, the bit sampled at that edge is discarded. At the same edge, both run lengths are cleared and the phases restart, `code_status` and `remote_loop_en` go to 0, and automatic mode begins by searching for the loop-up code.
- R6: In automatic mode, a qualified loop-up code sets `code_status` and `remote_loop_en` at one edge and restarts both runs. Both outputs then stay set whatever the data, until R7 or R5 applies.
- R7: In automatic mode with loop-back latched, a qualified loop-down code clears `code_status` and `remote_loop_en`. It also restarts both runs and returns to the loop-up search.
- R8: When `test_sel` equals 3'b110, `mode_sel` 2'b11 behaves as disabled.
- R9: While `local_loop` is 1, no loop-up grant happens and `remote_loop_en` is 0 from the next clock. If the latch was already set, `code_status` stays 1 and `remote_loop_en` comes back once `local_loop` returns to 0.
- R10: `irq_pulse` is high for exactly the cycle in which `code_status` differs from its previous value, provided `irq_en` was 1 at that edge. Otherwise it stays 0.
- R11: A bit presented with `rx_valid` at 0 has no effect on phase or run length.
- R12: A synchronous active-high `rst` clears status, loop-back enable, interrupt pulse, runs and phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered receive data bit |
| rx_valid | input | 1 | Marks `rx_bit` as a real data bit |
| mode_sel | input | 2 | Detection mode select |
| irq_en | input | 1 | Interrupt enable |
| test_sel | input | 3 | Test-mode field; 3'b110 blocks automatic mode |
| local_loop | input | 1 | Local analog loop-back is active |
| code_status | output | 1 | Loop-code status bit |
| irq_pulse | output | 1 | One-cycle interrupt on status change |
| remote_loop_en | output | 1 | Remote loop-back enable |

## Verification
The hardest situation to reach is automatic mode with loop-back already latched while `local_loop` toggles. To get there, the stimulus first qualifies the loop-up code with `local_loop` low. It then raises `local_loop` while the latch holds, and later clears it. This shows that the enable drops and returns without the status moving. A second hard-to-reach point is the exact qualification edge. The stimulus sends exactly `HOLD_CYCLES`+1 matching bits after a mode change, followed by an idle clock. Long random runs with random mode, test-field and loop-back changes are then compared on every clock against a behavioural model.

// File: rtl/loop_code_pkg.sv
package loop_code_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_AUTO = 2'b11
  } lc_mode_e;

  localparam logic [2:0] TEST_BLOCK_AUTO = 3'b110;

  function automatic lc_mode_e effective_mode(input logic [1:0] sel, input logic [2:0] tst);
    if (sel == MODE_AUTO && tst == TEST_BLOCK_AUTO) return MODE_OFF;
    return lc_mode_e'(sel);
  endfunction
endpackage

// File: rtl/lc_pattern_matcher.sv
module lc_pattern_matcher #(
  parameter int LEN  = 5,
  parameter int HOLD = 16,
  parameter int CW   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_valid,
  input  logic bit_in,
  output logic qualified
);
  localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD + 1);

  logic [PW-1:0] phase;
  logic [CW-1:0] run;
  logic          expected;

  assign expected  = (phase == LAST);
  assign qualified = (run == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
      run   <= '0;
    end else if (bit_valid) begin
      if (bit_in == expected) begin
        run   <= (run == TOP) ? run : run + 1'b1;
        phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end else begin
        run   <= '0;
        phase <= bit_in ? '0 : LAST;
      end
    end
  end
endmodule

// File: rtl/lc_mode_ctrl.sv
module lc_mode_ctrl
  import loop_code_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic [2:0] test_sel,
  input  logic       local_loop,
  input  logic       irq_en,
  input  logic       up_qual,
  input  logic       dn_qual,
  output logic       clr_codes,
  output logic       status,
  output logic       loop_en,
  output logic       irq
);
  lc_mode_e mode_eff, mode_q;
  logic     armed_dn, armed_dn_nx;
  logic     status_nx;
  logic     mode_chg;

  assign mode_eff = effective_mode(mode_sel, test_sel);
  assign mode_chg = (mode_eff != mode_q);

  always_comb begin
    status_nx   = status;
    armed_dn_nx = armed_dn;
    clr_codes   = 1'b0;
    if (mode_chg) begin
      status_nx   = 1'b0;
      armed_dn_nx = 1'b0;
      clr_codes   = 1'b1;
    end else begin
      unique case (mode_eff)
        MODE_OFF:  status_nx = 1'b0;
        MODE_UP:   status_nx = up_qual;
        MODE_DOWN: status_nx = dn_qual;
        MODE_AUTO: begin
          if (!armed_dn && up_qual && !local_loop) begin
            status_nx   = 1'b1;
            armed_dn_nx = 1'b1;
            clr_codes   = 1'b1;
          end else if (armed_dn && dn_qual) begin
            status_nx   = 1'b0;
            armed_dn_nx = 1'b0;
            clr_codes   = 1'b1;
          end
        end
        default: status_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_OFF;
      armed_dn <= 1'b0;
      status   <= 1'b0;
      loop_en  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      mode_q   <= mode_eff;
      armed_dn <= armed_dn_nx;
      status   <= status_nx;
      loop_en  <= armed_dn_nx && !local_loop && (mode_eff == MODE_AUTO);
      irq      <= irq_en && (status_nx != status);
    end
  end
endmodule

// File: rtl/loop_code_ctrl.sv
module loop_code_ctrl #(
  parameter int HOLD_CYCLES = 10_240_000,
  parameter int UP_LEN      = 5,
  parameter int DOWN_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_bit,
  input  logic       rx_valid,
  input  logic [1:0] mode_sel,
  input  logic       irq_en,
  input  logic [2:0] test_sel,
  input  logic       local_loop,
  output logic       code_status,
  output logic       irq_pulse,
  output logic       remote_loop_en
);
  localparam int CW     = $clog2(HOLD_CYCLES + 2);
  localparam int NCODES = 2;

  logic [NCODES-1:0] qual;
  logic              clr_codes;

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    lc_pattern_matcher #(
      .LEN  ((g == 0) ? UP_LEN : DOWN_LEN),
      .HOLD (HOLD_CYCLES),
      .CW   (CW)
    ) u_match (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_codes),
      .bit_valid (rx_valid),
      .bit_in    (rx_bit),
      .qualified (qual[g])
    );
  end

  lc_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .test_sel   (test_sel),
    .local_loop (local_loop),
    .irq_en     (irq_en),
    .up_qual    (qual[0]),
    .dn_qual    (qual[1]),
    .clr_codes  (clr_codes),
    .status     (code_status),
    .loop_en    (remote_loop_en),
    .irq        (irq_pulse)
  );
endmodule

// File: rtl/loop_code_ctrl_checker.sv
module loop_code_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       irq_en,
  input logic [2:0] test_sel,
  input logic       local_loop,
  input logic       code_status,
  input logic       irq_pulse,
  input logic       remote_loop_en
);
  p_reset_clears_r12: assert property (@(posedge clk)
    rst |=> (!code_status && !remote_loop_en && !irq_pulse));

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> (!code_status && !remote_loop_en));

  p_irq_on_change_r10: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (code_status != $past(code_status)));

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_en));

  p_no_grant_local_r9: assert property (@(posedge clk) disable iff (rst)
    remote_loop_en |-> !$past(local_loop));

  p_auto_only_r8: assert property (@(posedge clk) disable iff (rst)
    remote_loop_en |-> ($past(mode_sel) == 2'b11 && $past(test_sel) != 3'b110));

  p_loop_has_status_r6: assert property (@(posedge clk) disable iff (rst)
    remote_loop_en |-> code_status);
endmodule

bind loop_code_ctrl loop_code_ctrl_checker u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .irq_en(irq_en),
  .test_sel(test_sel), .local_loop(local_loop), .code_status(code_status),
  .irq_pulse(irq_pulse), .remote_loop_en(remote_loop_en)
);

// File: tb/loop_code_ctrl_tb.sv
module loop_code_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b0, rx_valid = 1'b0, irq_en = 1'b1, local_loop = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] test_sel = 3'b000;
  logic code_status, irq_pulse, remote_loop_en;

  int checks = 0, errors = 0, irq_seen = 0;

  // behavioural reference state
  int m_modeq = 0, m_armed = 0, m_status = 0, m_loop = 0, m_irq = 0;
  int ph[2] = '{0, 0};
  int rn[2] = '{0, 0};
  int clen[2] = '{5, 3};

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_code_ctrl #(.HOLD_CYCLES(H)) u_dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .mode_sel(mode_sel), .irq_en(irq_en), .test_sel(test_sel),
    .local_loop(local_loop), .code_status(code_status),
    .irq_pulse(irq_pulse), .remote_loop_en(remote_loop_en)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int eff, s, clr, upq, dnq;
    if (rst) begin
      m_modeq = 0; m_armed = 0; m_status = 0; m_loop = 0; m_irq = 0;
      for (int k = 0; k < 2; k++) begin ph[k] = 0; rn[k] = 0; end
      return;
    end
    eff = (mode_sel == 3 && test_sel == 6) ? 0 : int'(mode_sel);
    upq = (rn[0] > H); dnq = (rn[1] > H);
    s = m_status; clr = 0;
    if (eff != m_modeq) begin
      s = 0; m_armed = 0; clr = 1;
    end else if (eff == 0) s = 0;
    else if (eff == 1) s = upq;
    else if (eff == 2) s = dnq;
    else begin
      if (m_armed == 0 && upq && !local_loop) begin s = 1; m_armed = 1; clr = 1; end
      else if (m_armed == 1 && dnq) begin s = 0; m_armed = 0; clr = 1; end
    end
    m_irq = (irq_en && s != m_status) ? 1 : 0;
    m_status = s;
    m_loop = (m_armed == 1 && !local_loop && eff == 3) ? 1 : 0;
    m_modeq = eff;
    for (int k = 0; k < 2; k++) begin
      if (clr) begin ph[k] = 0; rn[k] = 0; end
      else if (rx_valid) begin
        int e;
        e = (ph[k] == clen[k] - 1) ? 1 : 0;
        if (int'(rx_bit) == e) begin
          if (rn[k] < H + 1) rn[k]++;
          ph[k] = (ph[k] + 1) % clen[k];
        end else begin
          rn[k] = 0;
          ph[k] = rx_bit ? 0 : clen[k] - 1;
        end
      end
    end
  endtask

  task automatic tick(logic v, logic b);
    rx_valid = v; rx_bit = b;
    @(posedge clk);
    model_step();
    #1;
    check("R4 status", code_status, m_status);
    check("R6 loop_en", remote_loop_en, m_loop);
    check("R10 irq", irq_pulse, m_irq);
    if (irq_pulse) irq_seen++;
    @(negedge clk);
  endtask

  task automatic send_code(int len, int n);
    for (int i = 0; i < n; i++) tick(1'b1, (i % len) == len - 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
    check("R12 reset status", code_status, 0);
    check("R12 reset loop", remote_loop_en, 0);
    check("R12 reset irq", irq_pulse, 0);
    rst = 1'b0;

    // R3: exact qualification edge, manual loop-up
    mode_sel = 2'b01; tick(1'b0, 1'b0);
    send_code(5, H + 1);
    check("R3 not yet", code_status, 0);
    tick(1'b0, 1'b0);
    check("R3 qualified", code_status, 1);
    check("R4 manual no loop", remote_loop_en, 0);

    // R2: stray 1 breaks the run
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    check("R2 break", code_status, 0);

    // R11: invalid bits ignored
    send_code(5, H + 6);
    for (int i = 0; i < 10; i++) tick(1'b0, i[0]);
    check("R11 ignore invalid", code_status, 1);

    // R2: loop-down code not seen as loop-up
    send_code(3, 3 * H);
    check("R2 wrong code", code_status, 0);

    // R5 / R4: manual loop-down
    send_code(5, H + 6);
    mode_sel = 2'b10; tick(1'b0, 1'b0);
    check("R5 mode change clears", code_status, 0);
    send_code(3, H + 6);
    check("R4 manual down", code_status, 1);

    // R1 disabled
    mode_sel = 2'b00; tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R1 disabled", code_status, 0);

    // R6 / R7 automatic
    mode_sel = 2'b11; tick(1'b0, 1'b0);
    send_code(5, H + 6);
    check("R6 status", code_status, 1);
    check("R6 loop", remote_loop_en, 1);
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b1);
    check("R6 held", remote_loop_en, 1);
    send_code(3, H + 6);
    check("R7 status", code_status, 0);
    check("R7 loop", remote_loop_en, 0);

    // R9 local loop-back
    local_loop = 1'b1;
    send_code(5, H + 10);
    check("R9 no grant", remote_loop_en, 0);
    check("R9 no status", code_status, 0);
    local_loop = 1'b0;
    send_code(5, 10);
    check("R9 granted", remote_loop_en, 1);
    local_loop = 1'b1; tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    check("R9 drop loop", remote_loop_en, 0);
    check("R9 status kept", code_status, 1);
    local_loop = 1'b0; tick(1'b0, 1'b0);
    check("R9 back", remote_loop_en, 1);

    // R5 leaving auto
    mode_sel = 2'b01; tick(1'b0, 1'b0);
    check("R5 leave auto", remote_loop_en, 0);

    // R8 test field blocks auto
    test_sel = 3'b110; mode_sel = 2'b11; tick(1'b0, 1'b0);
    send_code(5, H + 10);
    check("R8 blocked status", code_status, 0);
    check("R8 blocked loop", remote_loop_en, 0);
    test_sel = 3'b000;

    // R10 interrupt disabled
    irq_en = 1'b0; mode_sel = 2'b01; irq_seen = 0;
    tick(1'b0, 1'b0);
    send_code(5, H + 6);
    send_code(3, 10);
    check("R10 no irq when disabled", irq_seen, 0);
    irq_en = 1'b1;

    // random soak compared each clock
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      if (r < 4) mode_sel = 2'($urandom_range(0, 3));
      else if (r < 6) local_loop = ~local_loop;
      else if (r < 7) test_sel = (test_sel == 3'b110) ? 3'b000 : 3'b110;
      else if (r < 9) irq_en = ~irq_en;
      if ((i / 300) % 3 == 2) tick($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1);
      else tick($urandom_range(0, 15) != 0, (i % (((i / 300) % 3 == 0) ? 5 : 3)) ==
                (((i / 300) % 3 == 0) ? 4 : 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule